// File: doc/BRIEF.md
# Reset Boot Vector Selector

This block picks the program counter and status word a processor starts with when it leaves reset. It keeps a small nonvolatile store of five bytes: a status byte and a four-byte boot vector that holds a 16-bit boot program counter and a 16-bit boot status word. The store is modelled as a register array with program and erase commands. When the status byte is zero and no strap override is present, the core starts at the normal reset address. Otherwise the stored boot vector is used, the boot ROM is enabled, and fetches from the top of user program space are blocked.

The decision is made once per reset. While the synchronised reset input is low, the strap pins and the status byte are sampled on every clock. The values sampled on the last clock before release are then held until the next reset. The data bus width strap is captured the same way. A programming error, whether reported from outside or caused by programming a byte that was not erased, writes a nonzero mark into the status byte. That forces the boot vector on the next reset.

Top module: `boot_vector_select`

## Requirements
- R1: With status byte 00h and no strap override at evaluation, `init_pc` is 0000h, `init_psw` is 0000h, and `boot_mode` and `boot_rom_en` are 0.
- R2: With a nonzero status byte at evaluation, `boot_mode` and `boot_rom_en` are 1. `init_pc` is {byte 2, byte 1} and `init_psw` is {byte 4, byte 3}, where byte 0 is the status byte.
- R3: The strap override (`strap_psen_n`=0, `strap_ale`=1, `strap_ea`=1) selects the boot vector exactly as a nonzero status byte does. No other combination of these three pins does so.
- R4: Straps and storage are sampled on each clock edge where `rst_n` is 0, so the last such edge decides. While `rst_n` is 1, `init_pc`, `init_psw`, `boot_mode` and `bus16` do not change, even if the straps or the store change.
- R5: `fetch_block` is 1 exactly when `boot_mode` is 1 and `fetch_addr` is at or above F800h.
- R6: From power-up the store holds status 00h, boot program counter F800h and boot status word 8000h.
- R7: An erase command (`nv_op`=2'b10) at any address sets all five bytes to 00h in the next cycle.
- R8: A program command (`nv_op`=2'b01, address 0..4) writes `nv_wdata` only if that byte has been erased since it was last written. Otherwise the byte keeps its value, `prog_err` is 1 for one cycle after the command, and the status byte becomes 01h. The status byte counts as erased at power-up; the vector bytes do not.
- R9: `prog_err_in` sets the status byte to 01h in the next cycle. If it coincides with an erase, the status byte ends at 01h and the four vector bytes end at 00h.
- R10: `bus16` holds `strap_busw` as sampled under R4.
- R11: `nv_rdata` shows the stored byte at `nv_addr` (0..4) in the same cycle. For addresses 5..7 it shows 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronised reset, active low |
| strap_psen_n | input | 1 | Strap: program strobe pin level |
| strap_ale | input | 1 | Strap: address latch pin level |
| strap_ea | input | 1 | Strap: external access pin level |
| strap_busw | input | 1 | Strap: bus width (0 = 8-bit, 1 = 16-bit) |
| nv_valid | input | 1 | Storage command valid |
| nv_op | input | 2 | 01 program, 10 erase |
| nv_addr | input | 3 | Byte address: 0 status, 1..4 vector |
| nv_wdata | input | 8 | Program data |
| prog_err_in | input | 1 | External programming error report |
| fetch_addr | input | 16 | Current program fetch address |
| nv_rdata | output | 8 | Stored byte at nv_addr |
| init_pc | output | 16 | Initial program counter |
| init_psw | output | 16 | Initial status word |
| boot_mode | output | 1 | Boot vector selected at last reset |
| boot_rom_en | output | 1 | Boot ROM enabled |
| fetch_block | output | 1 | Fetch from blocked user region |
| bus16 | output | 1 | Captured 16-bit bus strap |
| prog_err | output | 1 | Program without prior erase, one-cycle pulse |

## Verification
An erase command and an external programming-error report can land on the same clock edge. Both write the status byte: the erase wants 00h and the error wants 01h. The bench drives both at once. It then reads the status byte and a vector byte through `nv_rdata`, and follows with a reset to confirm that the error mark won (status 01h, boot mode entered) while the vector bytes were still cleared to zero.

// File: rtl/boot_vector_select.sv
module boot_vector_select #(
  parameter logic [15:0] DEF_BPC    = 16'hF800,
  parameter logic [15:0] DEF_BPSW   = 16'h8000,
  parameter logic [15:0] RESET_PC   = 16'h0000,
  parameter logic [15:0] RESET_PSW  = 16'h0000,
  parameter logic [15:0] BLOCK_BASE = 16'hF800,
  parameter logic [7:0]  ERR_MARK   = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_psen_n,
  input  logic        strap_ale,
  input  logic        strap_ea,
  input  logic        strap_busw,
  input  logic        nv_valid,
  input  logic [1:0]  nv_op,
  input  logic [2:0]  nv_addr,
  input  logic [7:0]  nv_wdata,
  input  logic        prog_err_in,
  input  logic [15:0] fetch_addr,
  output logic [7:0]  nv_rdata,
  output logic [15:0] init_pc,
  output logic [15:0] init_psw,
  output logic        boot_mode,
  output logic        boot_rom_en,
  output logic        fetch_block,
  output logic        bus16,
  output logic        prog_err
);
  localparam int NB = 5;
  localparam logic [1:0] OP_PROG  = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b10;

  logic [7:0]    mem_q [NB] = '{8'h00, DEF_BPC[7:0], DEF_BPC[15:8], DEF_BPSW[7:0], DEF_BPSW[15:8]};
  logic [NB-1:0] erased_q   = 5'b00001;
  logic          prog_err_q = 1'b0;

  logic [15:0] pc_q, psw_q;
  logic        boot_q, bus16_q;

  wire addr_ok  = nv_addr < 3'(NB);
  wire do_erase = nv_valid && nv_op == OP_ERASE;
  wire do_prog  = nv_valid && nv_op == OP_PROG && addr_ok;
  wire prog_ok  = do_prog && erased_q[nv_addr];
  wire prog_bad = do_prog && !erased_q[nv_addr];
  wire set_err  = prog_bad || prog_err_in;

  always_ff @(posedge clk) begin
    if (do_erase) begin
      for (int i = 0; i < NB; i++) mem_q[i] <= 8'h00;
      erased_q <= '1;
    end else if (prog_ok) begin
      mem_q[nv_addr]    <= nv_wdata;
      erased_q[nv_addr] <= 1'b0;
    end
    if (set_err) begin
      mem_q[0]    <= ERR_MARK;
      erased_q[0] <= 1'b0;
    end
    prog_err_q <= prog_bad;
  end

  assign nv_rdata = addr_ok ? mem_q[nv_addr] : 8'h00;
  assign prog_err = prog_err_q;

  wire strap_force = !strap_psen_n && strap_ale && strap_ea;
  wire take_vec    = (mem_q[0] != 8'h00) || strap_force;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q  <= take_vec;
      pc_q    <= take_vec ? {mem_q[2], mem_q[1]} : RESET_PC;
      psw_q   <= take_vec ? {mem_q[4], mem_q[3]} : RESET_PSW;
      bus16_q <= strap_busw;
    end
  end

  assign init_pc     = pc_q;
  assign init_psw    = psw_q;
  assign boot_mode   = boot_q;
  assign boot_rom_en = boot_q;
  assign bus16       = bus16_q;
  assign fetch_block = boot_q && (fetch_addr >= BLOCK_BASE);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(init_pc) && $stable(init_psw) && $stable(boot_mode) && $stable(bus16)));

  assert_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_erase && !prog_err_in) |=> (mem_q[0] == 8'h00 && mem_q[1] == 8'h00 && mem_q[2] == 8'h00
                                    && mem_q[3] == 8'h00 && mem_q[4] == 8'h00));

  assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_bad |=> (prog_err && mem_q[0] == ERR_MARK));

  assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_bad && nv_addr != 3'd0) |=> (mem_q[$past(nv_addr)] == $past(nv_rdata)));

  assert_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err_in |=> (mem_q[0] == ERR_MARK));

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err |-> $past(do_prog));
endmodule

// File: tb/boot_vector_select_test.sv
`timescale 1ns/1ps
module boot_vector_select_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic psen_n = 1'b1, ale = 1'b1, ea = 1'b1, busw = 1'b0;
  logic nv_valid = 1'b0;
  logic [1:0] nv_op = 2'b00;
  logic [2:0] nv_addr = 3'd0;
  logic [7:0] nv_wdata = 8'h00;
  logic prog_err_in = 1'b0;
  logic [15:0] fetch_addr = 16'h0000;
  logic [7:0] nv_rdata;
  logic [15:0] init_pc, init_psw;
  logic boot_mode, boot_rom_en, fetch_block, bus16, prog_err;

  boot_vector_select uut (
    .clk(clk), .rst_n(rst_n), .strap_psen_n(psen_n), .strap_ale(ale), .strap_ea(ea),
    .strap_busw(busw), .nv_valid(nv_valid), .nv_op(nv_op), .nv_addr(nv_addr),
    .nv_wdata(nv_wdata), .prog_err_in(prog_err_in), .fetch_addr(fetch_addr),
    .nv_rdata(nv_rdata), .init_pc(init_pc), .init_psw(init_psw), .boot_mode(boot_mode),
    .boot_rom_en(boot_rom_en), .fetch_block(fetch_block), .bus16(bus16), .prog_err(prog_err));

  int total = 0, bad = 0;
  logic last_err;

  // {status, bpc, bpsw, psen_n, ale, ea, busw, expect_boot}
  localparam int NV = 6;
  localparam logic [44:0] VEC [NV] = '{
    {8'h00, 16'h1234, 16'h5678, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h5A, 16'h1234, 16'h5678, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h00, 16'hABCD, 16'h00FF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h00, 16'hABCD, 16'h00FF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h00, 16'hABCD, 16'h00FF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hFF, 16'hF800, 16'h8000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nv_cmd(input logic [1:0] op, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    nv_valid = 1'b1; nv_op = op; nv_addr = a; nv_wdata = d;
    @(posedge clk); #1;
    last_err = prog_err;
    @(negedge clk);
    nv_valid = 1'b0; nv_op = 2'b00;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    nv_addr = a; #1;
    v = nv_rdata;
  endtask

  task automatic do_reset(input logic p, input logic l, input logic e, input logic w);
    @(negedge clk);
    rst_n = 1'b0; psen_n = p; ale = l; ea = e; busw = w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    // R6/R1: factory state, normal boot
    do_reset(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R1 pc", init_pc, 16'h0000);
    chk("R1 psw", init_psw, 16'h0000);
    chk("R1 boot_mode", {15'b0, boot_mode}, 16'h0);
    chk("R1 rom_en", {15'b0, boot_rom_en}, 16'h0);
    fetch_addr = 16'hF800; #1;
    chk("R5 no block in normal boot", {15'b0, fetch_block}, 16'h0);

    // R3/R6: strap override with factory vector
    do_reset(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R6 factory bpc", init_pc, 16'hF800);
    chk("R6 factory bpsw", init_psw, 16'h8000);
    chk("R3 strap boot_mode", {15'b0, boot_mode}, 16'h1);
    chk("R3 rom_en", {15'b0, boot_rom_en}, 16'h1);
    chk("R10 bus16", {15'b0, bus16}, 16'h1);
    fetch_addr = 16'hF7FF; #1;
    chk("R5 below base", {15'b0, fetch_block}, 16'h0);
    fetch_addr = 16'hF800; #1;
    chk("R5 at base", {15'b0, fetch_block}, 16'h1);
    fetch_addr = 16'hFFFF; #1;
    chk("R5 top", {15'b0, fetch_block}, 16'h1);

    // R4: change straps while running, outputs hold
    @(negedge clk); psen_n = 1'b1; busw = 1'b0;
    repeat (3) @(posedge clk); #1;
    chk("R4 hold pc", init_pc, 16'hF800);
    chk("R4 hold boot_mode", {15'b0, boot_mode}, 16'h1);
    chk("R4 hold bus16", {15'b0, bus16}, 16'h1);

    // R8: program a never-erased vector byte
    nv_cmd(2'b01, 3'd2, 8'h55);
    chk("R8 prog_err pulse", {15'b0, last_err}, 16'h1);
    @(posedge clk); #1;
    chk("R8 prog_err one cycle", {15'b0, prog_err}, 16'h0);
    peek(3'd2, rb);
    chk("R8 byte kept", {8'h0, rb}, 16'h00F8);
    peek(3'd0, rb);
    chk("R8 status marked", {8'h0, rb}, 16'h0001);
    do_reset(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 boot after error pc", init_pc, 16'hF800);
    chk("R2 boot after error mode", {15'b0, boot_mode}, 16'h1);
    chk("R10 bus16 low", {15'b0, bus16}, 16'h0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      logic [7:0] st;
      logic [15:0] bpc, bpsw, epc, epsw;
      logic p, l, e, w, eb;
      {st, bpc, bpsw, p, l, e, w, eb} = VEC[k];
      nv_cmd(2'b10, 3'd0, 8'h00);
      nv_cmd(2'b01, 3'd1, bpc[7:0]);
      nv_cmd(2'b01, 3'd2, bpc[15:8]);
      nv_cmd(2'b01, 3'd3, bpsw[7:0]);
      nv_cmd(2'b01, 3'd4, bpsw[15:8]);
      if (st != 8'h00) nv_cmd(2'b01, 3'd0, st);
      chk("R8 program after erase ok", {15'b0, last_err}, 16'h0);
      do_reset(p, l, e, w);
      epc  = eb ? bpc  : 16'h0000;
      epsw = eb ? bpsw : 16'h0000;
      chk("R2/R3 table pc", init_pc, epc);
      chk("R2/R3 table psw", init_psw, epsw);
      chk("R2/R3 table boot_mode", {15'b0, boot_mode}, {15'b0, eb});
      chk("R10 table bus16", {15'b0, bus16}, {15'b0, w});
    end

    // R9: erase and external error on the same edge
    @(negedge clk);
    nv_valid = 1'b1; nv_op = 2'b10; nv_addr = 3'd3; prog_err_in = 1'b1;
    @(negedge clk);
    nv_valid = 1'b0; nv_op = 2'b00; prog_err_in = 1'b0;
    peek(3'd0, rb);
    chk("R9 status wins", {8'h0, rb}, 16'h0001);
    peek(3'd2, rb);
    chk("R9 vector erased", {8'h0, rb}, 16'h0000);
    peek(3'd5, rb);
    chk("R11 out of range read", {8'h0, rb}, 16'h0000);
    do_reset(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R9 boot_mode", {15'b0, boot_mode}, 16'h1);
    chk("R9 pc zero vector", init_pc, 16'h0000);

    // R7: erase clears status; R8: second program of same byte rejected
    nv_cmd(2'b10, 3'd6, 8'h00);
    peek(3'd0, rb);
    chk("R7 status cleared", {8'h0, rb}, 16'h0000);
    nv_cmd(2'b01, 3'd3, 8'h11);
    chk("R8 first program ok", {15'b0, last_err}, 16'h0);
    nv_cmd(2'b01, 3'd3, 8'h22);
    chk("R8 second program error", {15'b0, last_err}, 16'h1);
    peek(3'd3, rb);
    chk("R11 read kept byte", {8'h0, rb}, 16'h0011);

    // R4: last reset cycle decides (status 01h now, clear it first)
    nv_cmd(2'b10, 3'd0, 8'h00);
    @(negedge clk);
    rst_n = 1'b0; psen_n = 1'b0; ale = 1'b1; ea = 1'b1;
    @(negedge clk);
    @(negedge clk); ale = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R4 last cycle no override", {15'b0, boot_mode}, 16'h0);
    @(negedge clk);
    rst_n = 1'b0; psen_n = 1'b1;
    @(negedge clk);
    @(negedge clk); psen_n = 1'b0; ale = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R4 last cycle override", {15'b0, boot_mode}, 16'h1);

    // R4: store changes while running do not move outputs
    nv_cmd(2'b01, 3'd0, 8'h77);
    psen_n = 1'b1;
    @(posedge clk); #1;
    chk("R4 hold after store change", init_pc, 16'h0000);
    chk("R4 hold mode", {15'b0, boot_mode}, 16'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule